// File: doc/BRIEF.md
# Strap-Addressed I2C Command Slave

This block is a slave-only I2C port. A host uses it to pass command bytes to a processing core and to read back a one-byte status. The host always drives SCL and always starts every transfer. The block never stretches the clock.

Each received write byte goes to the core as a one-cycle strobe with the byte beside it. On a read, the block shifts out a status byte made from a 2-bit code that the core supplies. It pulls SDA low only through an open-drain enable, and the line needs an external pull-up.

The 7-bit address has a fixed upper part. Its two low bits come from strap pins. A mode pin chooses between this port and another serial port that shares the same pins. The block samples the mode pin and the straps while reset is held, and ignores them after that.

SCL and SDA each pass through a two-flop synchroniser and a glitch filter before START, STOP and the clock edges are decoded. At a system clock of a few tens of MHz or more, the added latency leaves a wide margin for both 100 kbit/s and 400 kbit/s buses.

Top module: `i2c_cmd_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal binary 0,0,1,1,1,A2,A1 (MSB first), where A2 and A1 are the latched strap values. With straps A2=1 and A1=0 the address is 0x1E. The acknowledge is SDA held low during the ninth SCL pulse.
- R2: When the address does not match, the block leaves SDA released and raises no strobe for the rest of that transfer. It stays that way until the next START or STOP.
- R3: After a matching write address, each complete 8-bit data byte (MSB first) gives exactly one single-cycle pulse of cmd_valid while SCL is low, with cmd_data holding the byte. Each such byte is acknowledged.
- R4: SDA is only ever pulled low or released (sda_pull=1 means pull low). The pull is only ever asserted while SCL is low.
- R5: After a matching read address, each byte sent is 0x80 OR status_sel, MSB first. status_sel is sampled at the SCL falling edge that starts the byte. A master ACK starts another byte, and a master NACK ends sending until the next START.
- R6: A repeated START, with no STOP before it, restarts address matching. The direction of the new transfer is taken from the new address byte.
- R7: A STOP at any point returns the block to idle with SDA released. A partial byte is discarded and raises no strobe.
- R8: strap_sel, strap_a2 and strap_a1 are latched on the last clock cycle with rst high. Changes to them after reset have no effect.
- R9: When the latched strap_sel is 1, the port is inactive: it never pulls SDA and never raises cmd_valid.
- R10: An SCL or SDA pulse shorter than FILT_LEN system clocks (3 by default) is ignored, and the byte being received is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_sel | input | 1 | Mode strap: 0 selects this I2C port |
| strap_a2 | input | 1 | Address strap, address bit 1 |
| strap_a1 | input | 1 | Address strap, address bit 0 |
| status_sel | input | 2 | Status code from the core; byte sent is 0x80 OR this value |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| cmd_data | output | 8 | Last received command byte |
| cmd_valid | output | 1 | One-cycle strobe for cmd_data |

## Verification
A wrong bit counter or shift register shows up within the same byte. The acknowledge on the ninth clock goes missing or lands a clock early, and cmd_data differs from the byte the host sent. A state machine that misses START, STOP or a repeated START shows up in the next transfer as a missing acknowledge, a false one, or a stray strobe. A wrong strap latch shows up as the wrong address being acknowledged from the first transfer after reset. A filter that lets through a short pulse corrupts the byte being received at its ACK.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK
  } slv_state_t;

  localparam logic [4:0] ADDR_FIXED  = 5'b00111;
  localparam logic [7:0] STATUS_BASE = 8'h80;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter logic       RST_VAL     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_LEN + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   filt_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= {SYNC_STAGES{RST_VAL}};
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
  end

  // The filtered level follows the synchronised level only after it has
  // differed for FILT_LEN consecutive cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else if (sync_q[SYNC_STAGES-1] == filt_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      cnt_q  <= '0;
      filt_q <= sync_q[SYNC_STAGES-1];
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dout = filt_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl;
      sda_d <= sda;
    end
  end

  assign scl_rise  =  scl & ~scl_d;
  assign scl_fall  = ~scl &  scl_d;
  assign start_det =  scl &  scl_d &  sda_d & ~sda;
  assign stop_det  =  scl &  scl_d & ~sda_d &  sda;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_cmd_pkg::*;
#(
  parameter int STATUS_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [6:0]          addr7,
  input  logic                sda,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  input  logic [STATUS_W-1:0] status_sel,
  output logic                sda_pull,
  output logic [7:0]          cmd_data,
  output logic                cmd_valid
);
  slv_state_t state_q;
  logic [2:0] bitcnt_q;
  logic [7:0] rx_q;
  logic [7:0] tx_q;
  logic       done_q;
  logic       rw_q;
  logic       nack_q;
  logic [7:0] status_byte;

  assign status_byte = STATUS_BASE | 8'(status_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bitcnt_q  <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      done_q    <= 1'b0;
      rw_q      <= 1'b0;
      nack_q    <= 1'b0;
      sda_pull  <= 1'b0;
      cmd_data  <= '0;
      cmd_valid <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      if (!en) begin
        state_q  <= ST_IDLE;
        sda_pull <= 1'b0;
      end else if (start_det) begin
        state_q  <= ST_ADDR;
        bitcnt_q <= '0;
        done_q   <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        done_q   <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WR_DATA: begin
            if (scl_rise) begin
              rx_q     <= {rx_q[6:0], sda};
              bitcnt_q <= bitcnt_q + 1'b1;
              done_q   <= (bitcnt_q == 3'd7);
            end else if (scl_fall && done_q) begin
              done_q <= 1'b0;
              if (state_q == ST_ADDR) begin
                if (rx_q[7:1] == addr7) begin
                  sda_pull <= 1'b1;
                  rw_q     <= rx_q[0];
                  state_q  <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                sda_pull  <= 1'b1;
                cmd_data  <= rx_q;
                cmd_valid <= 1'b1;
                state_q   <= ST_WR_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt_q <= '0;
              if (rw_q) begin
                tx_q     <= status_byte;
                sda_pull <= ~status_byte[7];
                state_q  <= ST_RD_DATA;
              end else begin
                sda_pull <= 1'b0;
                state_q  <= ST_WR_DATA;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              bitcnt_q <= '0;
              state_q  <= ST_WR_DATA;
            end
          end
          ST_RD_DATA: begin
            if (scl_fall) begin
              if (bitcnt_q == 3'd7) begin
                sda_pull <= 1'b0;
                state_q  <= ST_RD_ACK;
              end else begin
                tx_q     <= {tx_q[6:0], 1'b0};
                sda_pull <= ~tx_q[6];
                bitcnt_q <= bitcnt_q + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) begin
              nack_q <= sda;
            end else if (scl_fall) begin
              if (nack_q) begin
                state_q <= ST_IDLE;
              end else begin
                bitcnt_q <= '0;
                tx_q     <= status_byte;
                sda_pull <= ~status_byte[7];
                state_q  <= ST_RD_DATA;
              end
            end
          end
          default: begin
            sda_pull <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave
  import i2c_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int STATUS_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                strap_sel,
  input  logic                strap_a2,
  input  logic                strap_a1,
  input  logic [STATUS_W-1:0] status_sel,
  output logic                sda_pull,
  output logic [7:0]          cmd_data,
  output logic                cmd_valid
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] line_raw;
  logic [NLINES-1:0] line_f;
  logic              sel_q;
  logic [1:0]        strap_addr_q;
  logic              scl_rise, scl_fall, start_det, stop_det;

  assign line_raw = {sda_i, scl_i};

  genvar gi;
  generate
    for (gi = 0; gi < NLINES; gi++) begin : g_line
      i2c_line_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN),
        .RST_VAL    (1'b1)
      ) u_filt (
        .clk (clk),
        .rst (rst),
        .din (line_raw[gi]),
        .dout(line_f[gi])
      );
    end
  endgenerate

  // Straps follow the pins while reset is held and freeze on release.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q        <= strap_sel;
      strap_addr_q <= {strap_a2, strap_a1};
    end
  end

  i2c_bus_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl      (line_f[0]),
    .sda      (line_f[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_slave_fsm #(
    .STATUS_W(STATUS_W)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en        (~sel_q),
    .addr7     ({ADDR_FIXED, strap_addr_q}),
    .sda       (line_f[1]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .status_sel(status_sel),
    .sda_pull  (sda_pull),
    .cmd_data  (cmd_data),
    .cmd_valid (cmd_valid)
  );
endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic strap_sel,
  input logic sda_pull,
  input logic cmd_valid
);
  logic off_q;

  always_ff @(posedge clk) begin
    if (rst) off_q <= strap_sel;
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid); // R3

  AST_VALID_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !scl_i); // R3

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_i); // R4

  AST_OFF_NO_PULL: assert property (@(posedge clk) disable iff (rst)
    off_q |-> !sda_pull); // R9

  AST_OFF_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    off_q |-> !cmd_valid); // R9
endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .scl_i    (scl_i),
  .strap_sel(strap_sel),
  .sda_pull (sda_pull),
  .cmd_valid(cmd_valid)
);

// File: tb/i2c_cmd_slave_bench.sv
module i2c_cmd_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 25;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       strap_sel = 1'b0, strap_a2 = 1'b0, strap_a1 = 1'b0;
  logic [1:0] status_sel = 2'd0;
  logic       sda_pull;
  logic [7:0] cmd_data;
  logic       cmd_valid;
  logic       sda_line;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] rx_bytes [16];
  int rx_n = 0;
  logic pull_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  i2c_cmd_slave u_i2c_cmd_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .strap_sel(strap_sel), .strap_a2(strap_a2), .strap_a1(strap_a1),
    .status_sel(status_sel), .sda_pull(sda_pull),
    .cmd_data(cmd_data), .cmd_valid(cmd_valid)
  );

  always @(posedge clk) begin
    if (!rst && cmd_valid && rx_n < 16) begin
      rx_bytes[rx_n] = cmd_data;
      rx_n++;
    end
    if (!rst && sda_pull) pull_seen = 1'b1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic do_reset(input logic sel, input logic a2, input logic a1);
    rst = 1'b1; m_scl = 1'b1; m_sda = 1'b1;
    strap_sel = sel; strap_a2 = a2; strap_a1 = a1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    rx_n = 0; pull_seen = 1'b0;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tq(); m_scl = 1'b1; tq(); m_sda = 1'b0; tq(); m_scl = 1'b0; tq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tq(); m_scl = 1'b1; tq(); m_sda = 1'b1; tq();
  endtask

  task automatic wr_bit(input logic b, input bit glitch = 1'b0);
    m_sda = b;
    if (glitch) begin
      repeat (5) @(negedge clk);
      m_scl = 1'b1; @(negedge clk); m_scl = 1'b0;
      repeat (Q - 6) @(negedge clk);
    end else tq();
    m_scl = 1'b1; tq(2); m_scl = 1'b0; tq();
  endtask

  task automatic rd_bit(output logic b);
    m_sda = 1'b1; tq(); m_scl = 1'b1; tq(); b = sda_line; tq(); m_scl = 1'b0; tq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack, input int glitch_bit = -1);
    logic b;
    for (int i = 7; i >= 0; i--) wr_bit(v[i], i == glitch_bit);
    rd_bit(b);
    ack = ~b;
  endtask

  task automatic rd8(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rd_bit(b);
      v[i] = b;
    end
  endtask

  task automatic t_reset_state();
    do_reset(1'b0, 1'b1, 1'b0);
    check(sda_pull == 1'b0, "R4 reset pull", int'(sda_pull), 0);
    check(cmd_valid == 1'b0, "R3 reset valid", int'(cmd_valid), 0);
  endtask

  task automatic t_write();
    logic ack;
    bus_start();
    send_byte(8'h3C, ack);
    check(ack, "R1 addr 0x1E write ack", int'(ack), 1);
    send_byte(8'hA7, ack);
    check(ack, "R3 data ack", int'(ack), 1);
    send_byte(8'h01, ack);
    check(ack, "R3 data ack 2", int'(ack), 1);
    bus_stop();
    check(rx_n == 2, "R3 strobe count", rx_n, 2);
    check(rx_bytes[0] == 8'hA7, "R3 byte0", int'(rx_bytes[0]), 'hA7);
    check(rx_bytes[1] == 8'h01, "R3 byte1", int'(rx_bytes[1]), 'h01);
  endtask

  task automatic t_mismatch();
    logic ack;
    rx_n = 0; pull_seen = 1'b0;
    bus_start();
    send_byte(8'h38, ack);
    check(!ack, "R2 addr 0x1C nack", int'(ack), 0);
    send_byte(8'h55, ack);
    check(!ack, "R2 data ignored", int'(ack), 0);
    bus_stop();
    check(rx_n == 0 && !pull_seen, "R2 no strobe/pull", rx_n, 0);
  endtask

  task automatic t_read();
    logic ack; logic [7:0] v;
    status_sel = 2'd1;
    bus_start();
    send_byte(8'h3D, ack);
    check(ack, "R1 read addr ack", int'(ack), 1);
    rd8(v);
    check(v == 8'h81, "R5 first status", int'(v), 'h81);
    status_sel = 2'd3;
    wr_bit(1'b0);
    rd8(v);
    check(v == 8'h83, "R5 second status", int'(v), 'h83);
    wr_bit(1'b1);
    pull_seen = 1'b0;
    rd8(v);
    check(v == 8'hFF && !pull_seen, "R5 released after NACK", int'(v), 'hFF);
    bus_stop();
  endtask

  task automatic t_restart();
    logic ack; logic [7:0] v;
    rx_n = 0; status_sel = 2'd2;
    bus_start();
    send_byte(8'h3C, ack);
    send_byte(8'h5A, ack);
    bus_start();
    send_byte(8'h3D, ack);
    check(ack, "R6 restart addr ack", int'(ack), 1);
    rd8(v);
    check(v == 8'h82, "R6 read after restart", int'(v), 'h82);
    wr_bit(1'b1);
    bus_stop();
    check(rx_n == 1 && rx_bytes[0] == 8'h5A, "R6 write before restart", int'(rx_bytes[0]), 'h5A);
  endtask

  task automatic t_stop_mid();
    logic ack;
    rx_n = 0;
    bus_start();
    send_byte(8'h3C, ack);
    wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1);
    m_sda = 1'b0; tq(); bus_stop();
    check(rx_n == 0, "R7 partial byte discarded", rx_n, 0);
    check(sda_pull == 1'b0, "R7 released after stop", int'(sda_pull), 0);
    bus_start();
    send_byte(8'h3C, ack);
    send_byte(8'hC3, ack);
    bus_stop();
    check(rx_n == 1 && rx_bytes[0] == 8'hC3, "R7 next transfer ok", int'(rx_bytes[0]), 'hC3);
  endtask

  task automatic t_glitch();
    logic ack;
    rx_n = 0;
    bus_start();
    send_byte(8'h3C, ack);
    send_byte(8'h96, ack, 3);
    bus_stop();
    check(rx_n == 1 && rx_bytes[0] == 8'h96, "R10 scl glitch ignored", int'(rx_bytes[0]), 'h96);
  endtask

  task automatic t_strap_change();
    logic ack;
    strap_a2 = 1'b0; strap_a1 = 1'b1;
    bus_start(); send_byte(8'h3C, ack); bus_stop();
    check(ack, "R8 old address still acked", int'(ack), 1);
    bus_start(); send_byte(8'h3A, ack); bus_stop();
    check(!ack, "R8 new strap address ignored", int'(ack), 0);
    do_reset(1'b0, 1'b0, 1'b1);
    bus_start(); send_byte(8'h3A, ack); bus_stop();
    check(ack, "R1 addr 0x1D after reset", int'(ack), 1);
  endtask

  task automatic t_disabled();
    logic ack; int acks = 0;
    do_reset(1'b1, 1'b1, 1'b0);
    strap_sel = 1'b0;
    for (int a = 'h1C; a <= 'h1F; a++) begin
      bus_start(); send_byte(8'(a << 1), ack);
      if (ack) acks++;
      send_byte(8'h11, ack); bus_stop();
    end
    check(acks == 0 && !pull_seen, "R9 no ack when deselected", acks, 0);
    check(rx_n == 0, "R9 no strobe when deselected", rx_n, 0);
  endtask

  initial begin
    t_reset_state();
    t_write();
    t_mismatch();
    t_read();
    t_restart();
    t_stop_mid();
    t_glitch();
    t_strap_change();
    t_disabled();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule